// File: doc/BRIEF.md
# Gate Schedule Configuration Write Port

This block is the software-facing configuration entrance of a time-aware traffic shaper. Software cannot address the shaper's schedule parameters or its gate list directly. It stages a 32-bit value in a data register. It then writes a control word that names a target, and it sets the start flag in that same control word. The block then stores the staged value either into one of six schedule parameter registers or into one entry of the gate list memory.

The start flag stays high while the store is in progress, so it acts as a busy indication that software polls. After a fixed commit latency the block clears the flag. A target that does not exist is dropped and sets an error flag that stays set until reset. A read-back port lets the rest of the shaper, or a testbench, read any parameter register or list entry.

Top module: `gcl_access_port`

## Requirements
- R1: After reset the data register and the control register both read 0, the busy flag is 0, the error flag is 0 and all six parameter registers read 0.
- R2: A bus write at offset 0x84 loads the data register and a bus write at offset 0x80 loads the control register. A read at either offset returns the stored word; at 0x80, bit 0 shows the busy state.
- R3: A control write with bit 0 set starts an operation while the block is idle. Bit 0 of the control register then reads 1 for exactly COMMIT_LAT (default 3) clock cycles after the write edge, and after that it reads 0.
- R4: When control bit 2 is 1, the target address in control bits [15:8] selects a parameter register. The codes are 0 base time low, 1 base time high, 2 cycle time low, 3 cycle time high, 4 time extension and 5 list length. The staged data is in that register once busy clears.
- R5: When control bit 2 is 0, the target address in bits [15:8] is a gate list index. The staged data is in that list entry once busy clears.
- R6: A parameter address above 5 writes no parameter register and sets the error flag, which then stays 1 until reset.
- R7: A list index at or beyond LIST_DEPTH (default 64) writes no list entry and sets the error flag.
- R8: While busy is 1, bus writes to the data and control registers are ignored. The operation in flight commits the data that was staged when it started.
- R9: A control write with bit 0 clear stores the word but does not start an operation: busy stays 0 and no target changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register offset within the shaper window |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| err_flag | output | 1 | Sticky error flag for an invalid target |
| rb_list | input | 1 | Read-back select: 1 selects the list, 0 selects the parameters |
| rb_idx | input | 8 | Read-back index |
| rb_data | output | 32 | Read-back value; 0 for an index out of range |

## Verification
The assertions check four things on every cycle. Busy never lasts longer than the commit latency. Once the error flag is set it never drops. The staged data word holds steady while an operation is in flight. A control write starts an operation only when bit 0 is set and the block is idle. Three kinds of behaviour can only be shown by the bench's scenarios: that the right value lands in the right parameter or list entry, that invalid targets leave every entry unchanged, and that writes made during busy leave no trace in the committed contents.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned OFF_W       = 8;
    localparam int unsigned TGT_W       = 8;
    localparam int unsigned NUM_PARAMS  = 6;

    localparam logic [OFF_W-1:0] OFF_CTRL = 8'h80;
    localparam logic [OFF_W-1:0] OFF_DATA = 8'h84;

    localparam int unsigned BIT_START = 0;
    localparam int unsigned BIT_PSEL  = 2;
    localparam int unsigned TGT_LSB   = 8;

    typedef enum logic [2:0] {
        PRM_BASE_LO  = 3'd0,
        PRM_BASE_HI  = 3'd1,
        PRM_CYCLE_LO = 3'd2,
        PRM_CYCLE_HI = 3'd3,
        PRM_EXTEND   = 3'd4,
        PRM_LEN      = 3'd5
    } param_e;

    typedef struct packed {
        logic             start;
        logic             psel;
        logic [TGT_W-1:0] tgt;
    } op_t;

    function automatic op_t decode_ctrl(input logic [WORD_W-1:0] w);
        op_t o;
        o.start = w[BIT_START];
        o.psel  = w[BIT_PSEL];
        o.tgt   = w[TGT_LSB +: TGT_W];
        return o;
    endfunction

    function automatic logic param_ok(input logic [TGT_W-1:0] a);
        return a < TGT_W'(NUM_PARAMS);
    endfunction
endpackage

// File: rtl/gcl_regif.sv
module gcl_regif
    import gcl_pkg::*;
#(
    parameter int unsigned COMMIT_LAT = 3,
    parameter int unsigned LIST_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [OFF_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] data_q,
    output logic [WORD_W-1:0] ctrl_q,
    output logic              busy,
    output logic              prm_we,
    output logic              lst_we,
    output logic [TGT_W-1:0]  tgt,
    output logic              err
);
    localparam int unsigned CNT_W = $clog2(COMMIT_LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             commit;
    op_t              op;

    assign op     = decode_ctrl(ctrl_q);
    assign tgt    = op.tgt;
    assign commit = busy && (cnt_q == '0);
    assign prm_we = commit && op.psel && param_ok(op.tgt);
    assign lst_we = commit && !op.psel && (32'(op.tgt) < LIST_DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ctrl_q <= '0;
            busy   <= 1'b0;
            cnt_q  <= '0;
            err    <= 1'b0;
        end else if (busy) begin
            if (commit) begin
                busy           <= 1'b0;
                ctrl_q[BIT_START] <= 1'b0;
                if (!prm_we && !lst_we) err <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (bus_wen) begin
            if (bus_addr == OFF_DATA) data_q <= bus_wdata;
            if (bus_addr == OFF_CTRL) begin
                ctrl_q <= bus_wdata;
                if (bus_wdata[BIT_START]) begin
                    busy  <= 1'b1;
                    cnt_q <= CNT_W'(COMMIT_LAT - 1);
                end
            end
        end
    end
endmodule

// File: rtl/gcl_param_bank.sv
module gcl_param_bank
    import gcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [TGT_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [TGT_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] regs [NUM_PARAMS];

    for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_prm
        always_ff @(posedge clk) begin
            if (rst) regs[g] <= '0;
            else if (we && waddr == TGT_W'(g)) regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PARAMS; i++)
            if (raddr == TGT_W'(i)) rdata = regs[i];
    end
endmodule

// File: rtl/gcl_list_ram.sv
module gcl_list_ram
    import gcl_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic              clk,
    input  logic              we,
    input  logic [TGT_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [TGT_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[IDX_W'(waddr)] <= wdata;
    end

    assign rdata = (32'(raddr) < DEPTH) ? mem[IDX_W'(raddr)] : '0;
endmodule

// File: rtl/gcl_access_port.sv
module gcl_access_port
    import gcl_pkg::*;
#(
    parameter int unsigned COMMIT_LAT = 3,
    parameter int unsigned LIST_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wen,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        err_flag,
    input  logic        rb_list,
    input  logic [7:0]  rb_idx,
    output logic [31:0] rb_data
);
    logic [WORD_W-1:0] data_q, ctrl_q, prm_rd, lst_rd;
    logic              busy, prm_we, lst_we;
    logic [TGT_W-1:0]  tgt;

    gcl_regif #(.COMMIT_LAT(COMMIT_LAT), .LIST_DEPTH(LIST_DEPTH)) u_regif (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .data_q(data_q), .ctrl_q(ctrl_q), .busy(busy),
        .prm_we(prm_we), .lst_we(lst_we), .tgt(tgt), .err(err_flag)
    );

    gcl_param_bank u_prm (
        .clk(clk), .rst(rst), .we(prm_we), .waddr(tgt), .wdata(data_q),
        .raddr(rb_idx), .rdata(prm_rd)
    );

    gcl_list_ram #(.DEPTH(LIST_DEPTH)) u_lst (
        .clk(clk), .we(lst_we), .waddr(tgt), .wdata(data_q),
        .raddr(rb_idx), .rdata(lst_rd)
    );

    assign rb_data = rb_list ? lst_rd : prm_rd;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_DATA) bus_rdata = data_q;
        if (bus_addr == OFF_CTRL) begin
            bus_rdata = ctrl_q;
            bus_rdata[BIT_START] = busy;
        end
    end
endmodule

// File: rtl/gcl_access_checker.sv
module gcl_access_checker #(
    parameter int unsigned COMMIT_LAT = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_wen,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        busy,
    input logic        err,
    input logic [31:0] data_q
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 1;
    end

    // R3: busy never outlasts the commit latency
    p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> run_len < COMMIT_LAT);

    // R3: an idle start write raises busy on the next cycle
    p_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_wen && bus_addr == 8'h80 && bus_wdata[0]) |=> busy);

    // R9: a control write without start leaves the block idle
    p_no_launch_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_wen && bus_addr == 8'h80 && !bus_wdata[0]) |=> !busy);

    // R6: the error flag is sticky
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R8: staged data is frozen while busy
    p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(data_q));
endmodule

bind gcl_access_port gcl_access_checker #(.COMMIT_LAT(COMMIT_LAT)) u_chk (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .err(err_flag), .data_q(data_q)
);

// File: tb/sim_gcl_access_port.sv
module sim_gcl_access_port;
    localparam int LAT   = 3;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_flag;
    logic        rb_list = 1'b0;
    logic [7:0]  rb_idx = '0;
    logic [31:0] rb_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] prm_exp [6];

    always #2 clk = ~clk;

    gcl_access_port #(.COMMIT_LAT(LAT), .LIST_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_flag(err_flag),
        .rb_list(rb_list), .rb_idx(rb_idx), .rb_data(rb_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 8'h80;
    endtask

    function automatic logic [31:0] ctrl_word(input logic psel, input logic [7:0] t);
        return {16'h0, t, 5'b0, psel, 1'b0, 1'b1};
    endfunction

    // returns number of negedge samples with busy high
    task automatic wait_idle(output int n);
        n = 0;
        bus_addr = 8'h80;
        #0;
        while (bus_rdata[0] && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rb(input logic l, input logic [7:0] i, output logic [31:0] v);
        rb_list = l; rb_idx = i; #1; v = rb_data;
    endtask

    task automatic op(input logic psel, input logic [7:0] t, input logic [31:0] d, output int n);
        wr(8'h84, d);
        wr(8'h80, ctrl_word(psel, t));
        wait_idle(n);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_addr = 8'h80; #1; chk("R1 ctrl", bus_rdata, 32'h0);
        bus_addr = 8'h84; #1; chk("R1 data", bus_rdata, 32'h0);
        chk("R1 err", {31'b0, err_flag}, 32'h0);
        for (int i = 0; i < 6; i++) begin
            rb(1'b0, 8'(i), v); chk("R1 param", v, 32'h0);
        end
        @(negedge clk);

        // R2 register access
        wr(8'h84, 32'hA5A5_1234);
        bus_addr = 8'h84; #1; chk("R2 data rd", bus_rdata, 32'hA5A5_1234);
        // R9 control write without start
        wr(8'h80, 32'h0000_0304);
        #1; chk("R9 no busy", bus_rdata, 32'h0000_0304);
        @(negedge clk);
        bus_addr = 8'h80; #1; chk("R9 still idle", {31'b0, bus_rdata[0]}, 32'h0);
        rb(1'b0, 8'd3, v); chk("R9 param untouched", v, 32'h0);
        @(negedge clk);

        // R3 + R4 all parameters
        for (int i = 0; i < 6; i++) begin
            prm_exp[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
            op(1'b1, 8'(i), prm_exp[i], n);
            chk("R3 busy length", 32'(n), 32'(LAT));
        end
        for (int i = 0; i < 6; i++) begin
            rb(1'b0, 8'(i), v); chk("R4 param value", v, prm_exp[i]);
        end
        chk("R4 no err", {31'b0, err_flag}, 32'h0);
        @(negedge clk);

        // R5 full list sweep
        for (int i = 0; i < DEPTH; i++) begin
            op(1'b0, 8'(i), 32'(i) * 32'h0003_0007 + 32'h55, n);
        end
        for (int i = 0; i < DEPTH; i++) begin
            rb(1'b1, 8'(i), v); chk("R5 list value", v, 32'(i) * 32'h0003_0007 + 32'h55);
        end
        chk("R5 no err", {31'b0, err_flag}, 32'h0);
        @(negedge clk);

        // R6 invalid parameter addresses
        for (int a = 6; a < 16; a++) begin
            op(1'b1, 8'(a), 32'hDEAD_0000 + 32'(a), n);
            chk("R6 err set", {31'b0, err_flag}, 32'h1);
        end
        for (int i = 0; i < 6; i++) begin
            rb(1'b0, 8'(i), v); chk("R6 params unchanged", v, prm_exp[i]);
        end

        // R7 invalid list indices (err already sticky; list must be unchanged)
        op(1'b0, 8'd64, 32'hBAD0_0040, n);
        op(1'b0, 8'd255, 32'hBAD0_00FF, n);
        chk("R7 err", {31'b0, err_flag}, 32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            rb(1'b1, 8'(i), v); chk("R7 list unchanged", v, 32'(i) * 32'h0003_0007 + 32'h55);
        end
        @(negedge clk);

        // R8 writes during busy ignored
        wr(8'h84, 32'h7777_0001);
        wr(8'h80, ctrl_word(1'b0, 8'd10));
        wr(8'h84, 32'h9999_9999);
        wr(8'h80, ctrl_word(1'b1, 8'd2));
        wait_idle(n);
        bus_addr = 8'h84; #1; chk("R8 data kept", bus_rdata, 32'h7777_0001);
        bus_addr = 8'h80; #1; chk("R8 ctrl kept", bus_rdata, 32'h0000_0A00);
        rb(1'b1, 8'd10, v); chk("R8 list target", v, 32'h7777_0001);
        rb(1'b0, 8'd2, v); chk("R8 param untouched", v, prm_exp[2]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule